// File: doc/BRIEF.md
# Configuration Structure Source Selector

This block answers byte reads from the host's attribute-memory port and decides which of two non-volatile stores supplies each byte. After reset it walks a serial EEPROM word by word over a four-wire bit-serial link and copies the first 512 bytes of the card configuration structure into an internal byte buffer. While that copy runs, the block reports itself busy and turns every host read away with a one-cycle not-ready pulse.

Once the copy is done, reads below byte 512 come from the internal buffer with one cycle of latency. Reads at or above byte 512 go to an external parallel EEPROM, which may also hold execute-in-place code. These reads drive the parallel address, hold the output enable for a fixed number of wait states and then return the captured byte. If the first serial word reads back as all ones, no serial EEPROM is fitted. The load then stops at once, and the parallel store serves the low region too.

Top module: `cis_source_sel`

## Requirements
- R1: From reset until the load finishes, `hostBusy` is 1. A read requested in that time is answered, in the next cycle only, by a one-cycle `hostNotReady` pulse with no `hostRdAck`.
- R2: Each serial word read holds `seeCs` high and shifts out, MSB first on `seeDi`, the 11-bit command made of the bits 1,1,0 followed by the 8-bit word address. It then shifts in 16 data bits MSB first on `seeDo`. The device samples `seeDi` on the rising edge of `seeSk`, and the block reads words 0 to 255 in ascending order.
- R3: If word 0 reads back as 16'hFFFF, the serial EEPROM counts as absent. No further word is read and `hostBusy` falls.
- R4: With the serial EEPROM present, a read below byte 512 returns byte 2w as bits 7:0 of serial word w and byte 2w+1 as bits 15:8. `hostRdAck` and the data appear one cycle after the request.
- R5: A read at or above byte 512 drives `parAddr` with the host address and holds `parOe` high for exactly WAIT_STATES cycles, with `parAddr` stable. The byte on `parData` is returned with `hostRdAck` WAIT_STATES+1 cycles after the request.
- R6: With the serial EEPROM absent, reads below byte 512 also go to the parallel store, with the same timing and data as R5.
- R7: A request made while a parallel read is pending is ignored. Only the pending read is acknowledged, and it returns that read's byte.
- R8: `hostRdAck` and `hostNotReady` are never high together, and `hostBusy` does not rise again until the next reset.
- R9: A reset during the load abandons it and starts the load again from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostRdReq | input | 1 | One-cycle read request |
| hostAddr | input | 11 | Byte address of the read |
| hostRdAck | output | 1 | Read data valid pulse |
| hostNotReady | output | 1 | Read refused because the load is running |
| hostRdData | output | 8 | Returned byte |
| hostBusy | output | 1 | Load in progress |
| seeCs | output | 1 | Serial EEPROM select |
| seeSk | output | 1 | Serial EEPROM clock |
| seeDi | output | 1 | Serial data to the EEPROM |
| seeDo | input | 1 | Serial data from the EEPROM |
| parAddr | output | 11 | Parallel EEPROM address |
| parOe | output | 1 | Parallel EEPROM output enable |
| parData | input | 8 | Parallel EEPROM data |

## Verification
Directed reads at bytes 0, 1, 510, 511, 512 and 2047 check the byte order within a serial word and the exact boundary between the two stores. Seeded random addresses across the whole space then mix buffer hits and parallel reads, and the latency shows which path served each byte. The same sweep repeats with the serial model returning all ones, which must move the low region to the parallel store. A second request during a pending parallel read, a read while busy, and a reset mid-load separate the ignore, refuse and restart behaviour.

// File: rtl/cis_sel_pkg.sv
package cis_sel_pkg;
  typedef struct packed {
    logic rdStart;    // launch one serial word read
    logic bufWe;      // write a byte of the fetched word into the buffer
    logic bufHi;      // select the upper byte for that write
    logic bufRd;      // read the buffer at the host address
    logic parLoad;    // latch the host address for the parallel store
    logic parCapture; // capture parallel data as the reply
  } ctrlStrobes_t;
endpackage

// File: rtl/cis_see_reader.sv
module cis_see_reader #(
  parameter int WADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WADDR_W-1:0] wordAddr,
  output logic               done,
  output logic [15:0]        word,
  output logic               seeCs,
  output logic               seeSk,
  output logic               seeDi,
  input  logic               seeDo
);
  localparam int CMD_BITS = 3 + WADDR_W;
  localparam int TOT_BITS = CMD_BITS + 16;
  localparam int CNT_W    = $clog2(TOT_BITS + 1);
  localparam logic [CNT_W-1:0] CMD_END = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(TOT_BITS - 1);

  logic                active, phase;
  logic [CNT_W-1:0]    bitCnt;
  logic [CMD_BITS-1:0] cmdSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; phase <= 1'b0; bitCnt <= '0; cmdSr <= '0;
      seeCs <= 1'b0; seeSk <= 1'b0; seeDi <= 1'b0; done <= 1'b0; word <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          phase  <= 1'b0;
          bitCnt <= '0;
          cmdSr  <= {3'b110, wordAddr};
          seeCs  <= 1'b1;
          seeDi  <= 1'b1;
        end
      end else if (!phase) begin
        seeSk <= 1'b1;
        phase <= 1'b1;
      end else begin
        seeSk  <= 1'b0;
        phase  <= 1'b0;
        cmdSr  <= cmdSr << 1;
        seeDi  <= cmdSr[CMD_BITS-2];
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt >= CMD_END) word <= {word[14:0], seeDo};
        if (bitCnt == LAST) begin
          active <= 1'b0;
          seeCs  <= 1'b0;
          seeDi  <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cis_sel_ctrl.sv
module cis_sel_ctrl
  import cis_sel_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int LOW_AW      = 9,
  parameter int WAIT_STATES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRdReq,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              rdDone,
  input  logic [15:0]       rdWord,
  output ctrlStrobes_t      st,
  output logic [LOW_AW-2:0] loadIdx,
  output logic              hostBusy,
  output logic              hostRdAck,
  output logic              hostNotReady,
  output logic              parOe
);
  localparam int WC_W = $clog2(WAIT_STATES + 1);
  localparam logic [WC_W-1:0] WAIT_LAST = WC_W'(WAIT_STATES - 1);

  typedef enum logic [2:0] {S_LOAD_GO, S_LOAD_WAIT, S_WR_HI, S_READY, S_PAR} state_t;
  state_t          state;
  logic            seePresent;
  logic [WC_W-1:0] waitCnt;
  logic            highRegion;

  assign highRegion = |hostAddr[ADDR_W-1:LOW_AW];
  assign hostBusy   = (state == S_LOAD_GO) || (state == S_LOAD_WAIT) || (state == S_WR_HI);

  always_comb begin
    st = '0;
    case (state)
      S_LOAD_GO:   st.rdStart = 1'b1;
      S_LOAD_WAIT: st.bufWe = rdDone && !((loadIdx == '0) && (&rdWord));
      S_WR_HI:     begin st.bufWe = 1'b1; st.bufHi = 1'b1; end
      S_READY: if (hostRdReq) begin
        if (!highRegion && seePresent) st.bufRd = 1'b1;
        else                           st.parLoad = 1'b1;
      end
      S_PAR:       st.parCapture = (waitCnt == WAIT_LAST);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_LOAD_GO; seePresent <= 1'b1; loadIdx <= '0; waitCnt <= '0;
      hostRdAck <= 1'b0; hostNotReady <= 1'b0; parOe <= 1'b0;
    end else begin
      hostRdAck    <= 1'b0;
      hostNotReady <= hostBusy && hostRdReq;
      case (state)
        S_LOAD_GO:   state <= S_LOAD_WAIT;
        S_LOAD_WAIT: if (rdDone) begin
          if ((loadIdx == '0) && (&rdWord)) begin
            seePresent <= 1'b0;
            state      <= S_READY;
          end else state <= S_WR_HI;
        end
        S_WR_HI: begin
          if (&loadIdx) state <= S_READY;
          else begin
            loadIdx <= loadIdx + 1'b1;
            state   <= S_LOAD_GO;
          end
        end
        S_READY: if (hostRdReq) begin
          if (!highRegion && seePresent) hostRdAck <= 1'b1;
          else begin
            parOe   <= 1'b1;
            waitCnt <= '0;
            state   <= S_PAR;
          end
        end
        S_PAR: begin
          waitCnt <= waitCnt + 1'b1;
          if (waitCnt == WAIT_LAST) begin
            hostRdAck <= 1'b1;
            parOe     <= 1'b0;
            state     <= S_READY;
          end
        end
        default: state <= S_READY;
      endcase
    end
  end
endmodule

// File: rtl/cis_sel_dpath.sv
module cis_sel_dpath
  import cis_sel_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LOW_AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic [LOW_AW-2:0] loadIdx,
  input  logic [15:0]       rdWord,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        parData,
  output logic [ADDR_W-1:0] parAddr,
  output logic [7:0]        hostRdData
);
  localparam int BUF_BYTES = 1 << LOW_AW;

  logic [7:0] cisBuf [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (st.bufWe)
      cisBuf[{loadIdx, st.bufHi}] <= st.bufHi ? rdWord[15:8] : rdWord[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData <= '0;
      parAddr    <= '0;
    end else begin
      if (st.bufRd)      hostRdData <= cisBuf[hostAddr[LOW_AW-1:0]];
      if (st.parCapture) hostRdData <= parData;
      if (st.parLoad)    parAddr    <= hostAddr;
    end
  end
endmodule

// File: rtl/cis_source_sel.sv
module cis_source_sel
  import cis_sel_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int CIS_BYTES   = 512,
  parameter int WAIT_STATES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRdReq,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic              hostRdAck,
  output logic              hostNotReady,
  output logic [7:0]        hostRdData,
  output logic              hostBusy,
  output logic              seeCs,
  output logic              seeSk,
  output logic              seeDi,
  input  logic              seeDo,
  output logic [ADDR_W-1:0] parAddr,
  output logic              parOe,
  input  logic [7:0]        parData
);
  localparam int LOW_AW  = $clog2(CIS_BYTES);
  localparam int WADDR_W = LOW_AW - 1;

  ctrlStrobes_t       st;
  logic [WADDR_W-1:0] loadIdx;
  logic               rdDone;
  logic [15:0]        rdWord;

  cis_see_reader #(.WADDR_W(WADDR_W)) u_reader (
    .clk(clk), .rstN(rstN), .start(st.rdStart), .wordAddr(loadIdx),
    .done(rdDone), .word(rdWord),
    .seeCs(seeCs), .seeSk(seeSk), .seeDi(seeDi), .seeDo(seeDo)
  );

  cis_sel_ctrl #(.ADDR_W(ADDR_W), .LOW_AW(LOW_AW), .WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostRdReq(hostRdReq), .hostAddr(hostAddr),
    .rdDone(rdDone), .rdWord(rdWord), .st(st), .loadIdx(loadIdx),
    .hostBusy(hostBusy), .hostRdAck(hostRdAck), .hostNotReady(hostNotReady),
    .parOe(parOe)
  );

  cis_sel_dpath #(.ADDR_W(ADDR_W), .LOW_AW(LOW_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .loadIdx(loadIdx), .rdWord(rdWord),
    .hostAddr(hostAddr), .parData(parData), .parAddr(parAddr),
    .hostRdData(hostRdData)
  );
endmodule

// File: rtl/cis_source_sel_chk.sv
module cis_source_sel_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostRdReq,
  input logic              hostRdAck,
  input logic              hostNotReady,
  input logic              hostBusy,
  input logic              seeCs,
  input logic              seeSk,
  input logic              parOe,
  input logic [ADDR_W-1:0] parAddr
);
  a_r1_refuse_only_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    hostNotReady |-> ($past(hostBusy) && $past(hostRdReq)));

  a_r8_reply_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hostRdAck && hostNotReady));

  a_r8_busy_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(hostBusy));

  a_r2_clock_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    seeSk |-> seeCs);

  a_r5_par_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (parOe && $past(parOe)) |-> $stable(parAddr));

  a_r4_buffer_ack_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdAck && !$past(parOe)) |-> $past(hostRdReq));

  a_r5_ack_ends_par_access: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parOe) |-> hostRdAck);
endmodule

bind cis_source_sel cis_source_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostRdReq(hostRdReq), .hostRdAck(hostRdAck),
  .hostNotReady(hostNotReady), .hostBusy(hostBusy), .seeCs(seeCs),
  .seeSk(seeSk), .parOe(parOe), .parAddr(parAddr)
);

// File: tb/cis_source_sel_bench.sv
module cis_source_sel_bench;
  localparam int AW = 11;
  localparam int WS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostRdReq = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic hostRdAck, hostNotReady, hostBusy, seeCs, seeSk, seeDi, parOe;
  logic [7:0] hostRdData, parData;
  logic [AW-1:0] parAddr;
  logic seeDo = 1'b1;

  int checks = 0, fails = 0, cycles = 0;
  bit modelPresent = 1'b1;
  int bitK = 0, wordsSeen = 0, expWord = 0, cmdErrs = 0;
  logic [10:0] cmdM = '0;

  always #5 clk = ~clk;

  cis_source_sel #(.ADDR_W(AW), .CIS_BYTES(512), .WAIT_STATES(WS)) u_cis_source_sel (
    .clk(clk), .rstN(rstN), .hostRdReq(hostRdReq), .hostAddr(hostAddr),
    .hostRdAck(hostRdAck), .hostNotReady(hostNotReady), .hostRdData(hostRdData),
    .hostBusy(hostBusy), .seeCs(seeCs), .seeSk(seeSk), .seeDi(seeDi),
    .seeDo(seeDo), .parAddr(parAddr), .parOe(parOe), .parData(parData)
  );

  function automatic logic [15:0] seeWordFn(input logic [7:0] w);
    logic [7:0] lo;
    lo = w * 8'd3 + 8'd1;
    return {w ^ 8'hA5, lo};
  endfunction

  function automatic logic [7:0] parFn(input logic [AW-1:0] a);
    return a[7:0] ^ {a[10:8], 5'b01101};
  endfunction

  function automatic logic [7:0] expByte(input logic [AW-1:0] a, input bit present);
    logic [15:0] w;
    w = seeWordFn(a[8:1]);
    if (a < 11'd512 && present) return a[0] ? w[15:8] : w[7:0];
    return parFn(a);
  endfunction

  assign parData = parFn(parAddr);

  // serial EEPROM model
  always @(posedge seeCs) bitK = 0;
  always @(posedge seeSk) begin
    logic [15:0] w;
    if (bitK < 11) begin
      cmdM = {cmdM[9:0], seeDi};
      if (bitK == 10) begin
        if (cmdM != {3'b110, 8'(expWord)}) cmdErrs++;
        wordsSeen++;
        expWord++;
      end
    end else if (modelPresent) begin
      w = seeWordFn(cmdM[7:0]);
      seeDo = w[15 - (bitK - 11)];
    end
    bitK++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    seeDo = 1'b1;
    wordsSeen = 0; expWord = 0; cmdErrs = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitLoad(output int n);
    n = 0;
    while (hostBusy && n < 40000) begin @(negedge clk); n++; end
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [7:0] d,
                        output int lat, output int oeCnt, output int addrErr);
    @(negedge clk); hostRdReq = 1'b1; hostAddr = a;
    @(negedge clk); hostRdReq = 1'b0;
    lat = 1; oeCnt = 0; addrErr = 0;
    while (!hostRdAck && lat < 40) begin
      if (parOe) begin oeCnt++; if (parAddr != a) addrErr++; end
      @(negedge clk); lat++;
    end
    d = hostRdData;
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input bit present, input string req);
    logic [7:0] d; int lat, oe, ae;
    bit viaPar;
    viaPar = !(a < 11'd512 && present);
    doRead(a, d, lat, oe, ae);
    chk(d == expByte(a, present), req, d, expByte(a, present));
    chk(lat == (viaPar ? WS + 1 : 1), {req, " latency"}, lat, viaPar ? WS + 1 : 1);
    if (viaPar) chk(oe == WS && ae == 0, {req, " oe window"}, oe, WS);
  endtask

  initial begin
    int n;
    logic [7:0] d; int lat, oe, ae;
    logic [AW-1:0] a;
    bit gotExtra;
    void'($urandom(32'd1234));

    // R1: reset state and refusal while loading
    #1;
    chk(hostBusy && !hostRdAck && !hostNotReady && !parOe, "R1 reset state",
        {hostBusy, hostRdAck, hostNotReady, parOe}, 4'b1000);
    doReset();
    repeat (5) @(negedge clk);
    hostRdReq = 1'b1; hostAddr = 11'd3;
    @(negedge clk); hostRdReq = 1'b0;
    chk(hostNotReady && !hostRdAck, "R1 refuse while busy", {hostNotReady, hostRdAck}, 2'b10);
    @(negedge clk);
    chk(!hostNotReady && !hostRdAck, "R1 single refusal pulse", {hostNotReady, hostRdAck}, 0);

    // R2: full load with a present serial EEPROM
    waitLoad(n);
    chk(!hostBusy, "R2 load finishes", n, 0);
    chk(wordsSeen == 256, "R2 words read", wordsSeen, 256);
    chk(cmdErrs == 0, "R2 command bits and order", cmdErrs, 0);

    // R4 / R5 directed boundaries
    readCheck(11'd0, 1'b1, "R4 byte 0");
    readCheck(11'd1, 1'b1, "R4 byte 1");
    readCheck(11'd510, 1'b1, "R4 byte 510");
    readCheck(11'd511, 1'b1, "R4 byte 511");
    readCheck(11'd512, 1'b1, "R5 byte 512");
    readCheck(11'd2047, 1'b1, "R5 byte 2047");
    for (int i = 0; i < 120; i++) begin
      a = AW'($urandom_range(0, 2047));
      readCheck(a, 1'b1, (a < 11'd512) ? "R4 random" : "R5 random");
    end

    // R7: second request during a pending parallel read
    @(negedge clk); hostRdReq = 1'b1; hostAddr = 11'd600;
    @(negedge clk); hostRdReq = 1'b1; hostAddr = 11'd4;
    @(negedge clk); hostRdReq = 1'b0;
    n = 2;
    while (!hostRdAck && n < 40) begin @(negedge clk); n++; end
    chk(hostRdAck && hostRdData == parFn(11'd600), "R7 pending read data", hostRdData, parFn(11'd600));
    gotExtra = 1'b0;
    repeat (6) begin @(negedge clk); if (hostRdAck || hostNotReady) gotExtra = 1'b1; end
    chk(!gotExtra, "R7 ignored request gives no reply", gotExtra, 0);
    chk(!hostBusy, "R8 busy stays low", hostBusy, 0);

    // R3 / R6: serial EEPROM absent
    modelPresent = 1'b0;
    doReset();
    waitLoad(n);
    chk(!hostBusy && n < 200, "R3 short load when absent", n, 60);
    chk(wordsSeen == 1, "R3 only word 0 read", wordsSeen, 1);
    readCheck(11'd0, 1'b0, "R6 byte 0 absent");
    readCheck(11'd511, 1'b0, "R6 byte 511 absent");
    readCheck(11'd512, 1'b0, "R6 byte 512 absent");
    for (int i = 0; i < 40; i++) begin
      a = AW'($urandom_range(0, 2047));
      readCheck(a, 1'b0, "R6 random absent");
    end

    // R9: reset in the middle of a load
    modelPresent = 1'b1;
    doReset();
    repeat (700) @(negedge clk);
    chk(hostBusy && wordsSeen > 1, "R9 load under way", wordsSeen, 2);
    doReset();
    waitLoad(n);
    chk(wordsSeen == 256 && cmdErrs == 0, "R9 restart from word 0", wordsSeen, 256);
    readCheck(11'd77, 1'b1, "R9 buffer after restart");
    readCheck(11'd300, 1'b1, "R9 buffer word 150");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule